// File: doc/BRIEF.md
# Micromirror Test Pattern Generator

This block generates one slice of a test image every core clock for a micromirror array. The array is fed over four parallel data channels. The caller supplies four inputs on each cycle: an image index, a row number, a line-segment count and a reset-scheme code. One register stage later, the block presents 64 bits on each of channels A to D. These 256 bits are consecutive pixels of the addressed row. Alongside them it gives a data-valid flag and a selector. The selector tells the downstream control logic which clear or reset sequencer should drive the array. DDR serialization and the sequencers themselves live outside this block.

The block has seven images:

- a one-pixel frame with a small filled marker in the top-left corner;
- a comb of thin vertical lines;
- a fine checkerboard;
- thin and thick vertical bars, alternating;
- diagonal lines;
- a horizontal herringbone;
- an all-black image.

The all-black image always asks for a global clear, whatever reset scheme has been chosen. The line width and the frame height are parameters. Segment counts past the end of the line produce blank, invalid data.

Top module: `mtpg_top`

## Requirements
- R1: While `rst_n` is low, and on the cycle after the first rising edge on which it was low, all channel outputs are zero, `data_valid` is 0 and `rst_sel` is 0. Outside that window, every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency for row, image, segment and reset code alike).
- R2: Pixel column x of the line is given by x = seg_cnt*256 + 64*k + b. Here k is the channel (0=A, 1=B, 2=C, 3=D) and b is the bit within that channel. Bit 0 of channel A in segment 0 is the leftmost pixel. A set bit is a lit pixel.
- R3: Image 0 (frame) lights a pixel on any of these conditions: x=0, x=LINE_W-1, row=0, row=ROWS-1, or both x and row lie in 2..5. The defaults are LINE_W=1024 and ROWS=768.
- R4: Image 1 (thin lines) lights x where x mod 8 = 0.
- R5: Image 2 (checkerboard) lights a pixel when floor(x/4)+floor(row/4) is odd.
- R6: Image 3 (thin and thick bars) lights x where x mod 16 = 0 or x mod 16 is in 8..11.
- R7: Image 4 (diagonal) lights a pixel when x mod 16 = row mod 16.
- R8: Image 5 (herringbone) works on bands 8 pixels wide. Where floor(x/8) is even, it lights x mod 8 = row mod 8. Where floor(x/8) is odd, it lights x mod 8 = 7 - row mod 8.
- R9: Image 6 (black) and the spare index 7 give all-zero data. They set `rst_sel` to 4 (global clear) regardless of `rst_type`.
- R10: For images 0 to 5, `rst_sel` takes one of four values set by `rst_type`: 0 (single block) for code 00, 1 (dual block) for 01, 2 (global) for 10, and 3 (quad block) for 11.
- R11: `data_valid` is 1 exactly when the captured segment count is below LINE_W/256 (4 by default). When it is 0, all four channels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_idx | input | 3 | Image index |
| row_in | input | 11 | Row being generated |
| seg_cnt | input | 4 | Segment of the line being generated |
| rst_type | input | 2 | Reset scheme code |
| ch_a | output | 64 | Channel A data, pixels 0..63 of the segment |
| ch_b | output | 64 | Channel B data, pixels 64..127 of the segment |
| ch_c | output | 64 | Channel C data, pixels 128..191 of the segment |
| ch_d | output | 64 | Channel D data, pixels 192..255 of the segment |
| data_valid | output | 1 | Segment lies within the active line |
| rst_sel | output | 3 | Clear/reset sequencer select |

## Verification
The captured index, row and segment feed the data on the very next cycle, so a wrong value in any of them shows up as a wrong pixel within one clock. A row held back by an extra stage shows as the frame edges and diagonals offset by one row. Lines that are skewed or mirrored within a segment reveal a swapped channel or a reversed bit order. A wrongly decoded reset code or black image shows on `rst_sel` on the same cycle as the data it belongs to.

// File: rtl/mtpg_pkg.sv
package mtpg_pkg;
   typedef enum logic [2:0] {
      SRC_SINGLE = 3'd0,
      SRC_DUAL   = 3'd1,
      SRC_GLOBAL = 3'd2,
      SRC_QUAD   = 3'd3,
      SRC_GCLEAR = 3'd4
   } rst_src_e;

   typedef enum logic [2:0] {
      IMG_FRAME     = 3'd0,
      IMG_THIN      = 3'd1,
      IMG_CHECKER   = 3'd2,
      IMG_THINTHICK = 3'd3,
      IMG_DIAG      = 3'd4,
      IMG_HERRING   = 3'd5,
      IMG_BLACK     = 3'd6,
      IMG_SPARE     = 3'd7
   } img_e;
endpackage

// File: rtl/mtpg_stage.sv
module mtpg_stage #(
   parameter int ROW_W  = 11,
   parameter int SEG_CW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        pat_d,
   input  logic [ROW_W-1:0]  row_d,
   input  logic [SEG_CW-1:0] seg_d,
   input  logic [1:0]        type_d,
   output mtpg_pkg::img_e    pat_q,
   output logic [ROW_W-1:0]  row_q,
   output logic [SEG_CW-1:0] seg_q,
   output logic [1:0]        type_q,
   output logic              live_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_q  <= mtpg_pkg::IMG_FRAME;
         row_q  <= '0;
         seg_q  <= '0;
         type_q <= '0;
         live_q <= 1'b0;
      end else begin
         pat_q  <= mtpg_pkg::img_e'(pat_d);
         row_q  <= row_d;
         seg_q  <= seg_d;
         type_q <= type_d;
         live_q <= 1'b1;
      end
   end
endmodule

// File: rtl/mtpg_render.sv
module mtpg_render #(
   parameter int SEG_PIX = 256,
   parameter int LINE_W  = 1024,
   parameter int ROWS    = 768,
   parameter int ROW_W   = 11,
   parameter int SEG_CW  = 4
) (
   input  mtpg_pkg::img_e    pat_q,
   input  logic [ROW_W-1:0]  row_q,
   input  logic [SEG_CW-1:0] seg_q,
   input  logic              live_q,
   output logic [SEG_PIX-1:0] seg_bits,
   output logic              in_line
);
   import mtpg_pkg::*;
   localparam int SEGS = LINE_W / SEG_PIX;
   localparam int XW   = SEG_CW + $clog2(SEG_PIX);

   assign in_line = live_q && (int'(seg_q) < SEGS);

   for (genvar c = 0; c < SEG_PIX; c++) begin : g_pix
      logic [XW-1:0] x;
      logic          on;
      assign x = XW'(seg_q) * XW'(SEG_PIX) + XW'(c);
      always_comb begin
         case (pat_q)
            IMG_FRAME: on = (x == '0) || (x == XW'(LINE_W - 1)) ||
                            (row_q == '0) || (row_q == ROW_W'(ROWS - 1)) ||
                            ((x >= XW'(2)) && (x <= XW'(5)) &&
                             (row_q >= ROW_W'(2)) && (row_q <= ROW_W'(5)));
            IMG_THIN:      on = (x[2:0] == 3'd0);
            IMG_CHECKER:   on = x[2] ^ row_q[2];
            IMG_THINTHICK: on = (x[3:0] == 4'd0) || (x[3:2] == 2'b10);
            IMG_DIAG:      on = (x[3:0] == row_q[3:0]);
            IMG_HERRING:   on = x[3] ? (x[2:0] == ~row_q[2:0])
                                     : (x[2:0] == row_q[2:0]);
            default:       on = 1'b0;
         endcase
      end
      assign seg_bits[c] = on && in_line;
   end
endmodule

// File: rtl/mtpg_rsel.sv
module mtpg_rsel (
   input  mtpg_pkg::img_e   pat_q,
   input  logic [1:0]       type_q,
   input  logic             live_q,
   output mtpg_pkg::rst_src_e src
);
   import mtpg_pkg::*;
   always_comb begin
      if (!live_q) begin
         src = SRC_SINGLE;
      end else if (pat_q == IMG_BLACK || pat_q == IMG_SPARE) begin
         src = SRC_GCLEAR;
      end else begin
         case (type_q)
            2'b00:   src = SRC_SINGLE;
            2'b01:   src = SRC_DUAL;
            2'b10:   src = SRC_GLOBAL;
            default: src = SRC_QUAD;
         endcase
      end
   end
endmodule

// File: rtl/mtpg_top.sv
module mtpg_top #(
   parameter int CH_W   = 64,
   parameter int LINE_W = 1024,
   parameter int ROWS   = 768,
   parameter int ROW_W  = 11,
   parameter int SEG_CW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        pat_idx,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [SEG_CW-1:0] seg_cnt,
   input  logic [1:0]        rst_type,
   output logic [CH_W-1:0]   ch_a,
   output logic [CH_W-1:0]   ch_b,
   output logic [CH_W-1:0]   ch_c,
   output logic [CH_W-1:0]   ch_d,
   output logic              data_valid,
   output logic [2:0]        rst_sel
);
   import mtpg_pkg::*;
   localparam int CHANNELS = 4;
   localparam int SEG_PIX  = CHANNELS * CH_W;
   localparam int SEGS     = LINE_W / SEG_PIX;

   if (LINE_W % SEG_PIX != 0) begin : g_bad_width
      $error("LINE_W must be a whole number of segments");
   end
   if (SEGS < 1 || SEGS > (1 << SEG_CW)) begin : g_bad_segs
      $error("segment count does not fit SEG_CW");
   end
   if (ROWS < 1 || ROWS > (1 << ROW_W)) begin : g_bad_rows
      $error("ROWS does not fit ROW_W");
   end

   img_e              pat_q;
   logic [ROW_W-1:0]  row_q;
   logic [SEG_CW-1:0] seg_q;
   logic [1:0]        type_q;
   logic              live_q;
   logic [SEG_PIX-1:0] seg_bits;
   logic              in_line;
   rst_src_e          src;
   logic [CH_W-1:0]   ch_data [CHANNELS];

   mtpg_stage #(.ROW_W(ROW_W), .SEG_CW(SEG_CW)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .pat_d(pat_idx), .row_d(row_in), .seg_d(seg_cnt), .type_d(rst_type),
      .pat_q(pat_q), .row_q(row_q), .seg_q(seg_q), .type_q(type_q),
      .live_q(live_q)
   );

   mtpg_render #(.SEG_PIX(SEG_PIX), .LINE_W(LINE_W), .ROWS(ROWS),
                 .ROW_W(ROW_W), .SEG_CW(SEG_CW)) u_render (
      .pat_q(pat_q), .row_q(row_q), .seg_q(seg_q), .live_q(live_q),
      .seg_bits(seg_bits), .in_line(in_line)
   );

   mtpg_rsel u_rsel (
      .pat_q(pat_q), .type_q(type_q), .live_q(live_q), .src(src)
   );

   for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
      assign ch_data[k] = seg_bits[k*CH_W +: CH_W];
   end

   assign ch_a       = ch_data[0];
   assign ch_b       = ch_data[1];
   assign ch_c       = ch_data[2];
   assign ch_d       = ch_data[3];
   assign data_valid = in_line;
   assign rst_sel    = src;
endmodule

// File: rtl/mtpg_chk.sv
module mtpg_chk #(
   parameter int CH_W   = 64,
   parameter int SEGS   = 4,
   parameter int ROW_W  = 11,
   parameter int SEG_CW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        pat_idx,
   input logic [ROW_W-1:0]  row_in,
   input logic [SEG_CW-1:0] seg_cnt,
   input logic [1:0]        rst_type,
   input logic [CH_W-1:0]   ch_a,
   input logic [CH_W-1:0]   ch_b,
   input logic [CH_W-1:0]   ch_c,
   input logic [CH_W-1:0]   ch_d,
   input logic              data_valid,
   input logic [2:0]        rst_sel
);
   assert_valid_in_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (int'($past(seg_cnt)) < SEGS));

   assert_blank_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> (ch_a == '0 && ch_b == '0 && ch_c == '0 && ch_d == '0));

   assert_black_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pat_idx) >= 3'd6) |->
         (rst_sel == 3'd4 && ch_a == '0 && ch_d == '0));

   assert_type_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pat_idx) < 3'd6) |-> (rst_sel == {1'b0, $past(rst_type)}));

   assert_thin_comb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && $past(pat_idx) == 3'd1) |-> (ch_c == {(CH_W/8){8'h01}}));

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!data_valid && rst_sel == 3'd0));
endmodule

bind mtpg_top mtpg_chk #(.CH_W(CH_W), .SEGS(LINE_W / (4 * CH_W)),
                         .ROW_W(ROW_W), .SEG_CW(SEG_CW)) u_chk (.*);

// File: tb/mtpg_top_tb.sv
`timescale 1ns/1ps
module mtpg_top_tb;
   localparam int LINE_W = 1024;
   localparam int ROWS   = 768;
   localparam int SEGS   = LINE_W / 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  pat_idx = '0;
   logic [10:0] row_in = '0;
   logic [3:0]  seg_cnt = '0;
   logic [1:0]  rst_type = '0;
   logic [63:0] ch_a, ch_b, ch_c, ch_d;
   logic        data_valid;
   logic [2:0]  rst_sel;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // inputs applied before the last rising edge (the reference model's state)
   int  m_pat, m_row, m_seg, m_type;
   bit  m_live;
   bit  m_have = 0;

   always #2.5 clk = ~clk;

   mtpg_top u_dut (
      .clk(clk), .rst_n(rst_n), .pat_idx(pat_idx), .row_in(row_in),
      .seg_cnt(seg_cnt), .rst_type(rst_type),
      .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c), .ch_d(ch_d),
      .data_valid(data_valid), .rst_sel(rst_sel)
   );

   function automatic bit pix(int p, int x, int y);
      case (p)
         0: return (x == 0) || (x == LINE_W - 1) || (y == 0) || (y == ROWS - 1) ||
                   (x >= 2 && x <= 5 && y >= 2 && y <= 5);
         1: return (x % 8) == 0;
         2: return ((x / 4 + y / 4) % 2) == 1;
         3: return ((x % 16) == 0) || ((x % 16) >= 8 && (x % 16) <= 11);
         4: return (x % 16) == (y % 16);
         5: return ((x / 8) % 2 == 0) ? ((x % 8) == (y % 8)) : ((x % 8) == 7 - (y % 8));
         default: return 1'b0;
      endcase
   endfunction

   // R2: channel k, bit b holds column seg*256 + 64*k + b
   function automatic logic [63:0] exp_chan(int k);
      logic [63:0] v = '0;
      if (m_live && m_seg < SEGS)
         for (int b = 0; b < 64; b++) v[b] = pix(m_pat, m_seg * 256 + 64 * k + b, m_row);
      return v;
   endfunction

   function automatic string tag_of(int p);
      case (p)
         0: return "R3";  1: return "R4";  2: return "R5";  3: return "R6";
         4: return "R7";  5: return "R8";  default: return "R9";
      endcase
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      string t;
      logic [63:0] ea, eb, ec, ed;
      logic [2:0]  es;
      if (!m_have) return;
      if (!m_live) t = "R1";
      else if (m_seg >= SEGS) t = "R11";
      else t = tag_of(m_pat);
      ea = exp_chan(0); eb = exp_chan(1); ec = exp_chan(2); ed = exp_chan(3);
      check(t, "ch_a", ch_a, ea);
      check(t, "ch_b", ch_b, eb);
      check(t, "ch_c", ch_c, ec);
      check(t, "ch_d", ch_d, ed);
      check(m_live ? "R11" : "R1", "data_valid", 64'(data_valid),
            64'(m_live && m_seg < SEGS));
      if (!m_live) es = 3'd0;
      else if (m_pat >= 6) es = 3'd4;
      else es = 3'(m_type);
      check(!m_live ? "R1" : (m_pat >= 6 ? "R9" : "R10"), "rst_sel", 64'(rst_sel), 64'(es));
      if (m_live && m_pat == 1 && m_seg == 0)
         check("R2", "ch_d bit0 is column 192", 64'(ch_d[0]), 64'(1));
   endtask

   // one cycle: check what the last edge produced, then present new inputs
   task automatic step(bit rn, int p, int r, int s, int ty);
      @(negedge clk);
      compare_all();
      rst_n = rn; pat_idx = 3'(p); row_in = 11'(r); seg_cnt = 4'(s); rst_type = 2'(ty);
      m_live = rn; m_pat = p; m_row = r; m_seg = s; m_type = ty; m_have = 1;
   endtask

   initial begin
      int rows [10] = '{0, 1, 2, 5, 6, 9, 100, 766, 767, 768};
      int ty = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "ch_a in reset", ch_a, '0);
      check("R1", "valid in reset", 64'(data_valid), 64'(0));
      check("R1", "rst_sel in reset", 64'(rst_sel), 64'(0));
      m_have = 0;
      for (int p = 0; p < 8; p++) begin
         for (int ri = 0; ri < 10; ri++) begin
            for (int s = 0; s < 6; s++) begin
               step(1'b1, p, rows[ri], s, ty);
               ty = (ty + 1) % 4;
            end
         end
         if (p == 3) begin
            step(1'b0, 1, 3, 0, 2);
            step(1'b0, 4, 7, 1, 3);
         end
      end
      step(1'b1, 0, 0, 15, 1);
      step(1'b1, 0, 2047, 3, 2);
      step(1'b1, 0, 0, 0, 0);
      @(negedge clk);
      compare_all();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule